// File: doc/BRIEF.md
# Disk Sector Address Sequencer

This block holds the working disk address of a storage transfer: an 8-bit sector field, a 16-bit cylinder field and a 4-bit head field. A controller loads these fields, the addressing mode and a sector count from its command registers with a single strobe. It then pulses an advance input once for each sector the transfer completes.

On each advance the block moves the address to the following sector. The mode flag picks the stepping rule. In linear mode the three fields act as one packed 28-bit counter. In geometry mode the sector number is 1-based and rolls over into the head, and the head rolls over into the cylinder, using the sectors-per-track and head-count inputs.

A remaining-sector counter runs alongside the address. It marks the final sector of a transfer and the end of the transfer. On the final sector the address stays put, so it still names the last sector moved. A registered output gives the equivalent flat block number in either mode.

Top module: `sector_addr_seq`

## Requirements
- R1: After synchronous reset the outputs are: sector 1, cylinder 0, head 0, geometry mode (`lba_mode` = 0), remaining count 0, `done` = 1, `last_sector` = 0. One cycle later `lin_addr` is 0.
- R2: On `load` the block captures the fields. The sector comes from `ld_sect` and the cylinder from `ld_cyl`. The head comes from `ld_devhead[3:0]`, and `ld_devhead[6]` selects the mode (1 = linear, 0 = geometry). The remaining count is `ld_count`, except that a value of 0 loads 256.
- R3: When `load` and `advance` are high in the same cycle, only the load takes effect.
- R4: In linear mode an advance increments {head, cylinder, sector} as one 28-bit value. A sector wrapping from 255 to 0 carries into the cylinder, and a cylinder wrapping from 65535 to 0 carries into the head.
- R5: In geometry mode an advance increments the sector. If the result exceeds `spt`, the sector becomes 1 and the head increments.
- R6: In geometry mode, when the incremented head reaches `heads`, the head becomes 0 and the cylinder increments (modulo 65536).
- R7: An advance while the remaining count is 1 leaves sector, cylinder and head unchanged.
- R8: Each advance while the remaining count is nonzero decrements it by one. While the count is 0, advances change nothing.
- R9: `last_sector` is high exactly while the remaining count is 1, and `done` exactly while it is 0.
- R10: In linear mode `lin_addr` equals {head, cylinder, sector} as they were one cycle earlier.
- R11: In geometry mode `lin_addr` equals ((cylinder × heads + head) × spt + sector − 1) modulo 2^28. The fields and geometry used are those of one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture task-file values |
| ld_sect | input | 8 | Sector value to load |
| ld_cyl | input | 16 | Cylinder value to load |
| ld_devhead | input | 8 | Head in [3:0], linear-mode select in [6] |
| ld_count | input | 8 | Sector count, 0 means 256 |
| advance | input | 1 | One sector completed |
| spt | input | 8 | Sectors per track |
| heads | input | 5 | Head count (1 to 16) |
| cur_sect | output | 8 | Current sector field |
| cur_cyl | output | 16 | Current cylinder field |
| cur_head | output | 4 | Current head field |
| lba_mode | output | 1 | 1 when linear stepping is active |
| remaining | output | 9 | Sectors left in the transfer |
| last_sector | output | 1 | Remaining count is 1 |
| done | output | 1 | Remaining count is 0 |
| lin_addr | output | 28 | Flat block number, one cycle behind |

## Verification
A wrong carry or rollover in the stepping logic appears on the address fields at the first clock edge after the advance that crosses the boundary. It appears one edge later on `lin_addr`. A miscounted remaining counter shows immediately on `remaining`, `last_sector` and `done`. It also shows one transfer-end later as an address that moves on the final sector or that freezes a sector early. The reference model is compared on every cycle, so any such divergence is reported in the cycle it first becomes visible.

// File: rtl/sector_addr_pkg.sv
package sector_addr_pkg;
    parameter int SECT_W = 8;
    parameter int CYL_W  = 16;
    parameter int HEAD_W = 4;
    localparam int CNT_W = SECT_W + 1;
    localparam int LIN_W = HEAD_W + CYL_W + SECT_W;

    typedef struct packed {
        logic [HEAD_W-1:0] head;
        logic [CYL_W-1:0]  cyl;
        logic [SECT_W-1:0] sect;
    } disk_addr_t;

    typedef enum logic {
        MODE_GEOM   = 1'b0,
        MODE_LINEAR = 1'b1
    } step_mode_e;

    // Bit of the drive/head byte that selects linear stepping.
    localparam int MODE_BIT = 6;

    function automatic logic [CNT_W-1:0] count_from_taskfile(input logic [SECT_W-1:0] v);
        return (v == '0) ? CNT_W'(1 << SECT_W) : CNT_W'(v);
    endfunction
endpackage

// File: rtl/addr_step.sv
module addr_step
    import sector_addr_pkg::*;
(
    input  disk_addr_t        cur,
    input  step_mode_e        mode,
    input  logic [SECT_W-1:0] spt,
    input  logic [HEAD_W:0]   heads,
    output disk_addr_t        nxt
);
    logic [LIN_W-1:0]  packed_inc;
    logic [SECT_W:0]   sect_inc;
    logic [HEAD_W:0]   head_inc;

    always_comb begin
        packed_inc = cur + LIN_W'(1);
        sect_inc   = {1'b0, cur.sect} + (SECT_W+1)'(1);
        head_inc   = {1'b0, cur.head} + (HEAD_W+1)'(1);
        nxt        = cur;
        if (mode == MODE_LINEAR) begin
            nxt = disk_addr_t'(packed_inc);
        end else if (sect_inc > {1'b0, spt}) begin
            nxt.sect = SECT_W'(1);
            if (head_inc >= heads) begin
                nxt.head = '0;
                nxt.cyl  = cur.cyl + CYL_W'(1);
            end else begin
                nxt.head = head_inc[HEAD_W-1:0];
            end
        end else begin
            nxt.sect = sect_inc[SECT_W-1:0];
        end
    end
endmodule

// File: rtl/remain_ctr.sv
module remain_ctr
    import sector_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SECT_W-1:0] ld_count,
    input  logic              advance,
    output logic [CNT_W-1:0]  remaining,
    output logic              last_sector,
    output logic              done,
    output logic              move
);
    always_ff @(posedge clk) begin
        if (rst)
            remaining <= '0;
        else if (load)
            remaining <= count_from_taskfile(ld_count);
        else if (advance && remaining != '0)
            remaining <= remaining - CNT_W'(1);
    end

    assign last_sector = (remaining == CNT_W'(1));
    assign done        = (remaining == '0);
    assign move        = advance && !load && (remaining > CNT_W'(1));

    // R8: each accepted advance takes exactly one off the count
    p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && remaining != '0) |=> remaining == $past(remaining) - CNT_W'(1));

    // R8: an exhausted transfer ignores further advances
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && remaining == '0) |=> remaining == '0);
endmodule

// File: rtl/lin_addr_calc.sv
module lin_addr_calc
    import sector_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  disk_addr_t        cur,
    input  step_mode_e        mode,
    input  logic [SECT_W-1:0] spt,
    input  logic [HEAD_W:0]   heads,
    output logic [LIN_W-1:0]  lin_addr
);
    localparam int PW = LIN_W + 1;
    logic [PW-1:0] track;
    logic [PW-1:0] flat;

    always_comb begin
        track = PW'(cur.cyl) * PW'(heads) + PW'(cur.head);
        flat  = track * PW'(spt) + PW'(cur.sect) - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            lin_addr <= '0;
        else if (mode == MODE_LINEAR)
            lin_addr <= cur;
        else
            lin_addr <= flat[LIN_W-1:0];
    end
endmodule

// File: rtl/sector_addr_seq.sv
module sector_addr_seq
    import sector_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [7:0]        ld_sect,
    input  logic [15:0]       ld_cyl,
    input  logic [7:0]        ld_devhead,
    input  logic [7:0]        ld_count,
    input  logic              advance,
    input  logic [7:0]        spt,
    input  logic [4:0]        heads,
    output logic [7:0]        cur_sect,
    output logic [15:0]       cur_cyl,
    output logic [3:0]        cur_head,
    output logic              lba_mode,
    output logic [8:0]        remaining,
    output logic              last_sector,
    output logic              done,
    output logic [27:0]       lin_addr
);
    disk_addr_t addr_q, addr_nxt;
    step_mode_e mode_q;
    logic       move;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '{head: '0, cyl: '0, sect: SECT_W'(1)};
            mode_q <= MODE_GEOM;
        end else if (load) begin
            addr_q <= '{head: ld_devhead[HEAD_W-1:0], cyl: ld_cyl, sect: ld_sect};
            mode_q <= step_mode_e'(ld_devhead[MODE_BIT]);
        end else if (move) begin
            addr_q <= addr_nxt;
        end
    end

    addr_step u_step (
        .cur   (addr_q),
        .mode  (mode_q),
        .spt   (spt),
        .heads (heads),
        .nxt   (addr_nxt)
    );

    remain_ctr u_cnt (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .ld_count    (ld_count),
        .advance     (advance),
        .remaining   (remaining),
        .last_sector (last_sector),
        .done        (done),
        .move        (move)
    );

    lin_addr_calc u_lin (
        .clk      (clk),
        .rst      (rst),
        .cur      (addr_q),
        .mode     (mode_q),
        .spt      (spt),
        .heads    (heads),
        .lin_addr (lin_addr)
    );

    assign cur_sect = addr_q.sect;
    assign cur_cyl  = addr_q.cyl;
    assign cur_head = addr_q.head;
    assign lba_mode = (mode_q == MODE_LINEAR);

    // R3: a load beats a simultaneous advance
    p_load_wins_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur_sect == $past(ld_sect) && cur_cyl == $past(ld_cyl)
                  && cur_head == $past(ld_devhead[3:0])));

    // R7: the final sector leaves the address where it is
    p_freeze_last_r7: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && last_sector) |=>
            ($stable(cur_sect) && $stable(cur_cyl) && $stable(cur_head)));

    // R4: a full sector field in linear mode carries out to zero
    p_lin_carry_r4: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && lba_mode && remaining > 9'd1 && cur_sect == 8'hFF)
            |=> cur_sect == 8'h00);

    // R5: a valid geometry sector stays within 1..spt after a step
    p_geom_range_r5: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && !lba_mode && remaining > 9'd1
         && cur_sect != 8'd0 && cur_sect <= spt)
            |=> (cur_sect != 8'd0 && cur_sect <= $past(spt)));
endmodule

// File: tb/tb_sector_addr_seq.sv
module tb_sector_addr_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0, advance = 1'b0;
    logic [7:0]  ld_sect = '0, ld_devhead = '0, ld_count = '0, spt = 8'd4;
    logic [15:0] ld_cyl = '0;
    logic [4:0]  heads = 5'd2;
    logic [7:0]  cur_sect;
    logic [15:0] cur_cyl;
    logic [3:0]  cur_head;
    logic        lba_mode, last_sector, done;
    logic [8:0]  remaining;
    logic [27:0] lin_addr;

    sector_addr_seq dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int m_sect, m_cyl, m_head, m_rem, m_lin;
    bit m_mode;
    bit started = 0;
    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    always @(posedge clk) begin
        int nl, a;
        cycles++;
        if (m_mode) nl = (m_head << 24) | (m_cyl << 8) | m_sect;
        else        nl = ((m_cyl * int'(heads) + m_head) * int'(spt) + m_sect - 1) & 32'h0FFF_FFFF;
        if (rst) begin
            m_sect = 1; m_cyl = 0; m_head = 0; m_mode = 0; m_rem = 0; m_lin = 0;
        end else begin
            m_lin = nl;
            if (load) begin
                m_sect = ld_sect; m_cyl = ld_cyl; m_head = ld_devhead & 15;
                m_mode = ld_devhead[6];
                m_rem = (ld_count == 0) ? 256 : ld_count;
            end else if (advance && m_rem != 0) begin
                if (m_rem != 1) begin
                    if (m_mode) begin
                        a = ((m_head << 24) | (m_cyl << 8) | m_sect) + 1;
                        a = a & 32'h0FFF_FFFF;
                        m_sect = a & 255; m_cyl = (a >> 8) & 16'hFFFF; m_head = (a >> 24) & 15;
                    end else begin
                        m_sect++;
                        if (m_sect > int'(spt)) begin
                            m_sect = 1; m_head++;
                            if (m_head >= int'(heads)) begin
                                m_head = 0; m_cyl = (m_cyl + 1) & 16'hFFFF;
                            end
                        end
                    end
                end
                m_rem--;
            end
        end
        started = 1;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: %s actual=hung expected=finish", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic compare();
        checks++;
        if (cur_sect != m_sect[7:0] || cur_cyl != m_cyl[15:0] || cur_head != m_head[3:0]
            || lba_mode != m_mode || remaining != m_rem[8:0]
            || last_sector != (m_rem == 1) || done != (m_rem == 0) || lin_addr != m_lin[27:0]) begin
            fails++;
            $display("FAIL %s: actual s=%0d c=%0d h=%0d m=%0d rem=%0d last=%0d done=%0d lin=%0d expected s=%0d c=%0d h=%0d m=%0d rem=%0d last=%0d done=%0d lin=%0d",
                     cur_req, cur_sect, cur_cyl, cur_head, lba_mode, remaining, last_sector, done, lin_addr,
                     m_sect, m_cyl, m_head, m_mode, m_rem, (m_rem == 1), (m_rem == 0), m_lin);
        end
    endtask

    task automatic cyc(input logic ld, input logic adv);
        @(negedge clk);
        if (started) compare();
        load = ld; advance = adv;
    endtask

    task automatic setup(input int s, input int c, input int dh, input int n);
        ld_sect = s[7:0]; ld_cyl = c[15:0]; ld_devhead = dh[7:0]; ld_count = n[7:0];
    endtask

    initial begin
        repeat (3) cyc(0, 0);
        rst = 1'b0;
        cur_req = "R1";
        repeat (2) cyc(0, 0);

        // R2: linear load, head 3, count 5; R4 carries across sector and cylinder
        cur_req = "R2";
        setup(8'hFE, 16'hFFFF, 8'h43, 5);
        cyl_load_once();
        cur_req = "R4";
        for (int i = 0; i < 4; i++) cyc(0, 1);
        // R7: count at 1, advance must not move the address
        cur_req = "R7";
        cyc(0, 1);
        // R8: count exhausted, advances ignored
        cur_req = "R8";
        repeat (3) cyc(0, 1);
        cur_req = "R10";
        repeat (2) cyc(0, 0);

        // R5/R6/R11: geometry walk, spt 4, heads 2, count 0 -> 256 (R2)
        cur_req = "R2";
        spt = 8'd4; heads = 5'd2;
        setup(3, 7, 8'hA1, 0);
        cyl_load_once();
        cur_req = "R5";
        for (int i = 0; i < 4; i++) cyc(0, 1);
        cur_req = "R6";
        for (int i = 0; i < 12; i++) cyc(0, 1);
        cur_req = "R11";
        repeat (2) cyc(0, 0);

        // R6 cylinder wrap at 65535 with 16 heads
        cur_req = "R6";
        spt = 8'd255; heads = 5'd16;
        setup(255, 16'hFFFF, 8'h0F, 3);
        cyl_load_once();
        repeat (3) cyc(0, 1);

        // R3: load together with advance
        cur_req = "R3";
        setup(9, 100, 8'h02, 2);
        cyc(1, 1);
        cyc(0, 0);
        // R9: two-sector transfer flags
        cur_req = "R9";
        repeat (3) cyc(0, 1);
        cur_req = "R11";
        repeat (2) cyc(0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic cyl_load_once();
        cyc(1, 0);
        cyc(0, 0);
    endtask
endmodule